// File: doc/BRIEF.md
# Receive Error-Bit Policy

This block sits between the receive bit-timing checker and the bus line driver of a single-wire consumer-control receiver. The checker reports three kinds of timing fault as single-cycle events: a rising edge at the wrong time, a bit period that is too short, and a bit period that is too long. Along with these events the block sees whether the frame now arriving is a broadcast or is addressed to one device, and whether the receiver listens to all traffic.

From the events, that context and five configuration bits, the block makes two decisions. It decides whether reception of the frame is abandoned, and whether an error bit is driven onto the bus. An error bit is a single low pulse of a fixed length, and the block asks the line driver for it through a level output. A separate broadcast-quiet bit takes priority over the two per-error enables when the frame is a broadcast. A short-period fault in a broadcast frame stays silent whenever the receiver is listening to all traffic. Each kind of fault also sets a sticky flag. Software clears a flag by writing 1 to it.

Top module: `rx_err_policy`

## Requirements
- R1: In a directed frame, a rising-edge fault pulses `rx_abort` only when `cfg_stop_on_rise` is 1. Otherwise reception continues.
- R2: In a directed frame, a rising-edge fault requests an error bit only when both `cfg_stop_on_rise` and `cfg_rise_errbit` are 1.
- R3: In a directed frame, a long-period fault requests an error bit exactly when `cfg_long_errbit` is 1. Long-period and short-period faults always pulse `rx_abort`.
- R4: In a broadcast frame with `cfg_bcast_quiet` = 0, a rising-edge fault requests an error bit whenever `cfg_stop_on_rise` is 1, whatever the value of `cfg_rise_errbit`. A long-period fault always requests one, whatever the value of `cfg_long_errbit`.
- R5: In a broadcast frame with `cfg_bcast_quiet` = 1, no fault requests an error bit. The abort decision is unchanged.
- R6: A short-period fault requests an error bit, except in a broadcast frame while `full_listen` is 1 or `cfg_bcast_quiet` is 1.
- R7: A request raises `err_drive` on the clock edge that samples the event. `err_drive` stays high for exactly ERR_LEN cycles. Requests that arrive while it is high neither extend nor restart the pulse.
- R8: `rx_abort` is high for one cycle only, on the cycle after the event.
- R9: `err_flags` is sticky: bit 0 records rising-edge faults, bit 1 short-period faults and bit 2 long-period faults. Writing 1 to a bit of `flag_clr` clears only that bit. When an event and a clear hit the same bit in the same cycle, the event wins.
- R10: After reset, `rx_abort`, `err_drive` and `err_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_bcast | input | 1 | Frame in progress is a broadcast |
| full_listen | input | 1 | Receiver listens to all traffic |
| cfg_stop_on_rise | input | 1 | Rising-edge fault stops reception |
| cfg_rise_errbit | input | 1 | Error-bit enable for rising-edge faults |
| cfg_long_errbit | input | 1 | Error-bit enable for long-period faults |
| cfg_bcast_quiet | input | 1 | Suppress all error bits in broadcast frames |
| ev_rise | input | 1 | Rising-edge fault event |
| ev_short | input | 1 | Short-period fault event |
| ev_long | input | 1 | Long-period fault event |
| flag_clr | input | 3 | Write-1-to-clear strobes for err_flags |
| rx_abort | output | 1 | One-cycle pulse: abandon the frame |
| err_drive | output | 1 | High while the bus must be held low for an error bit |
| err_flags | output | 3 | Sticky fault flags {long, short, rise} |

## Verification
The bench sets up the cases in which the broadcast rules overturn the per-error enables. A design that gives the enables priority would stay silent on a broadcast rising-edge fault with its enable clear, or would drive on a quiet broadcast. It also sends a short-period fault in a broadcast frame while listening to all traffic. A design that misses this exemption would disturb the bus there. The bench counts the length of the error pulse and sends a second request in the middle of it. A counter that reloads would make the pulse too long. Finally, the bench clears one flag in the same cycle as a new event on that flag, and clears flags selectively. A design that lets the clear win, or that clears all flags at once, would lose a recorded fault.

// File: rtl/rx_err_policy.sv
module rx_err_policy #(
  parameter int ERR_LEN = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_bcast,
  input  logic       full_listen,
  input  logic       cfg_stop_on_rise,
  input  logic       cfg_rise_errbit,
  input  logic       cfg_long_errbit,
  input  logic       cfg_bcast_quiet,
  input  logic       ev_rise,
  input  logic       ev_short,
  input  logic       ev_long,
  input  logic [2:0] flag_clr,
  output logic       rx_abort,
  output logic       err_drive,
  output logic [2:0] err_flags
);
  localparam int CW = $clog2(ERR_LEN + 1);

  logic          want_rise, want_short, want_long, want_err, abort_now;
  logic [CW-1:0] cnt;

  // broadcast frames: quiet bit overrides the per-error enables
  assign want_rise  = is_bcast ? (!cfg_bcast_quiet && cfg_stop_on_rise)
                               : (cfg_stop_on_rise && cfg_rise_errbit);
  assign want_long  = is_bcast ? !cfg_bcast_quiet : cfg_long_errbit;
  assign want_short = !(is_bcast && (full_listen || cfg_bcast_quiet));

  assign want_err  = (ev_rise && want_rise) || (ev_short && want_short) ||
                     (ev_long && want_long);
  assign abort_now = ev_short || ev_long || (ev_rise && cfg_stop_on_rise);

  assign err_drive = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rx_abort  <= 1'b0;
      err_flags <= 3'b000;
    end else begin
      rx_abort  <= abort_now;
      err_flags <= (err_flags & ~flag_clr) | {ev_long, ev_short, ev_rise};
      if (cnt != '0)
        cnt <= cnt - 1'b1;
      else if (want_err)
        cnt <= CW'(ERR_LEN);
    end
  end
endmodule

// File: rtl/rx_err_policy_checker.sv
module rx_err_policy_checker #(
  parameter int ERR_LEN = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       is_bcast,
  input logic       cfg_stop_on_rise,
  input logic       cfg_bcast_quiet,
  input logic       ev_rise,
  input logic       ev_short,
  input logic       ev_long,
  input logic [2:0] flag_clr,
  input logic       rx_abort,
  input logic       err_drive,
  input logic [2:0] err_flags
);
  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else        run <= err_drive ? run + 1 : 0;
  end

  assert_short_aborts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_short || ev_long) |=> rx_abort);

  assert_rise_no_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise && !cfg_stop_on_rise && !ev_short && !ev_long) |=> !rx_abort);

  assert_quiet_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_drive && is_bcast && cfg_bcast_quiet) |=> !err_drive);

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_drive) |-> (run == ERR_LEN));

  assert_abort_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_abort && !ev_rise && !ev_short && !ev_long) |=> !rx_abort);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[0] && !flag_clr[0]) |=> err_flags[0]);

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_long |=> err_flags[2]);
endmodule

bind rx_err_policy rx_err_policy_checker #(.ERR_LEN(ERR_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_bcast(is_bcast),
  .cfg_stop_on_rise(cfg_stop_on_rise), .cfg_bcast_quiet(cfg_bcast_quiet),
  .ev_rise(ev_rise), .ev_short(ev_short), .ev_long(ev_long),
  .flag_clr(flag_clr), .rx_abort(rx_abort), .err_drive(err_drive),
  .err_flags(err_flags)
);

// File: tb/rx_err_policy_test.sv
module rx_err_policy_test;
  localparam int ERR_LEN = 24;
  localparam int NV = 14;
  // {bcast, listen, stop, risegen, longgen, quiet, rise, short, long, exp_abort, exp_err}
  localparam logic [10:0] VEC [NV] = '{
    11'b00010010000,  // R1 R2 directed rise, no stop
    11'b00100010010,  // R1 R2 directed rise, stop, no enable
    11'b00110010011,  // R1 R2 directed rise, stop and enable
    11'b00000000110,  // R3 directed long, enable clear
    11'b00001000111,  // R3 directed long, enable set
    11'b00000001011,  // R6 directed short
    11'b10100010011,  // R4 broadcast rise, stop, enable clear
    11'b10010010000,  // R4 broadcast rise, no stop, enable set
    11'b10000000111,  // R4 broadcast long, enable clear
    11'b10001100110,  // R5 quiet broadcast long
    11'b10110110010,  // R5 quiet broadcast rise
    11'b11000001010,  // R6 broadcast short in full listen
    11'b01000001011,  // R6 directed short in full listen
    11'b10000001011   // R6 broadcast short, reduced listen
  };

  logic clk = 0, rst_n = 0;
  logic is_bcast = 0, full_listen = 0, cfg_stop_on_rise = 0, cfg_rise_errbit = 0;
  logic cfg_long_errbit = 0, cfg_bcast_quiet = 0, ev_rise = 0, ev_short = 0, ev_long = 0;
  logic [2:0] flag_clr = 0;
  logic rx_abort, err_drive;
  logic [2:0] err_flags;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_err_policy #(.ERR_LEN(ERR_LEN)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (ERR_LEN + 3) @(negedge clk);
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 abort", rx_abort, 0);
    chk("R10 drive", err_drive, 0);
    chk("R10 flags", err_flags, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {is_bcast, full_listen, cfg_stop_on_rise, cfg_rise_errbit, cfg_long_errbit,
       cfg_bcast_quiet, ev_rise, ev_short, ev_long} = VEC[i][10:2];
      @(negedge clk);
      ev_rise = 0; ev_short = 0; ev_long = 0;
      chk($sformatf("vec%0d abort (R1 R3 R8 table)", i), rx_abort, VEC[i][1]);
      chk($sformatf("vec%0d errbit (R2 R4 R5 R6 table)", i), err_drive, VEC[i][0]);
      chk($sformatf("vec%0d flags R9", i), err_flags, {VEC[i][2], VEC[i][3], VEC[i][4]});
      settle();
    end

    // R7: pulse length, and a second request mid-pulse must not extend it
    begin
      int len = 0;
      is_bcast = 0; full_listen = 0; cfg_bcast_quiet = 0;
      ev_short = 1;
      @(negedge clk);
      ev_short = 0;
      while (err_drive && len < 4 * ERR_LEN) begin
        len++;
        if (len == ERR_LEN / 2) ev_short = 1;
        @(negedge clk);
        ev_short = 0;
      end
      chk("R7 pulse length with retrigger", len, ERR_LEN);
      // R8: abort from the mid-pulse event has already gone
      chk("R8 abort single cycle", rx_abort, 0);
    end
    settle();

    // R9: selective clear and set-wins
    ev_rise = 1; ev_long = 1; cfg_stop_on_rise = 0;
    @(negedge clk);
    ev_rise = 0; ev_long = 0;
    repeat (3) @(negedge clk);
    chk("R9 sticky", err_flags, 3'b101);
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = 3'b000;
    chk("R9 selective clear", err_flags, 3'b100);
    flag_clr = 3'b100; ev_long = 1;
    @(negedge clk);
    flag_clr = 3'b000; ev_long = 0;
    chk("R9 set wins over clear", err_flags, 3'b100);
    chk("R8 abort after long", rx_abort, 1);
    @(negedge clk);
    chk("R8 abort low next cycle", rx_abort, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule